// File: doc/BRIEF.md
# Register Rename Status Table

This block tracks, for every architectural register, whether the register holds a finished value or is still waiting for a result. A waiting register carries a producer tag, which is the name of the reservation station or load buffer that will compute the value. Tag zero means the stored value is valid. When an instruction issues, two read ports return its source operands as value/tag pairs. A rename port then stamps the destination register with the tag of the issuing station.

Completed results arrive on a shared result bus as a tag/value pair. Every register whose current tag equals the broadcast tag takes the value and becomes ready again. A register that was renamed again keeps its newer tag and ignores the older broadcast. Because of this, later writers supersede earlier ones, and only true read-after-write dependences make an instruction wait.

Top module: `rename_table`

## Requirements
- R1: After reset, every one of the 16 registers reads with tag 0 and value 0.
- R2: Each read port returns the addressed register's stored value and tag combinationally, in the same cycle the address is applied. A tag of 0 marks the value as valid.
- R3: A rename (renEn high, with renReg and a nonzero renTag) sets that register's tag to renTag from the next cycle on. The register's value is left unchanged.
- R4: A broadcast (bcastEn high, with nonzero bcastTag and bcastVal) updates every register whose tag equals bcastTag. From the next cycle, each such register holds bcastVal with tag 0. All other registers are unchanged.
- R5: A register renamed to a newer tag ignores a later broadcast of its older tag and keeps the newer tag.
- R6: A read of a register whose tag matches a broadcast in the same cycle returns bcastVal with tag 0.
- R7: When a rename and a matching broadcast hit the same register in the same cycle, the rename wins. The register ends with the new tag and its previous value.
- R8: A broadcast with tag 0 changes no register and is not forwarded to either read port.
- R9: A read of a register being renamed in the same cycle returns the contents from before the rename.
- R10: In a cycle with no rename and no broadcast, every register keeps its value and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 4 | Read port A register index |
| rdValA | output | 32 | Read port A value |
| rdTagA | output | 4 | Read port A producer tag (0 = valid) |
| rdAddrB | input | 4 | Read port B register index |
| rdValB | output | 32 | Read port B value |
| rdTagB | output | 4 | Read port B producer tag (0 = valid) |
| renEn | input | 1 | Rename strobe |
| renReg | input | 4 | Destination register to rename |
| renTag | input | 4 | Tag of the issuing station (nonzero) |
| bcastEn | input | 1 | Result bus valid |
| bcastTag | input | 4 | Result bus producer tag |
| bcastVal | input | 32 | Result bus value |

## Verification
A corrupted tag in an entry appears at a read port on the first read of that register after the fault. It also changes behaviour later, because the entry then captures the wrong broadcast or misses the right one. The next read after that broadcast exposes the error. A missing or mis-prioritised update becomes visible one cycle after the rename or broadcast that caused it. Forwarding faults appear in the same cycle as the broadcast. The random phase reads both ports every cycle while tags are drawn from a small pool. Stale-tag and double-match cases therefore occur within a few cycles.

// File: rtl/rt_pkg.sv
package rt_pkg;
  parameter int unsigned NREGS  = 16;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned TAG_W  = 4;
  localparam int unsigned ADDR_W = $clog2(NREGS);

  // strobes from control to datapath
  typedef struct packed {
    logic [NREGS-1:0] renSel;   // entry takes a new tag
    logic [NREGS-1:0] capSel;   // entry captures the bus value
    logic             fwdA;     // port A returns the bus value
    logic             fwdB;     // port B returns the bus value
  } strobes_t;
endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
(
  input  logic                    renEn,
  input  logic [ADDR_W-1:0]       renReg,
  input  logic                    bcastEn,
  input  logic [TAG_W-1:0]        bcastTag,
  input  logic [ADDR_W-1:0]       rdAddrA,
  input  logic [ADDR_W-1:0]       rdAddrB,
  input  logic [NREGS*TAG_W-1:0]  tagFlat,
  output strobes_t                strb
);
  logic [NREGS-1:0] matchVec;
  logic [NREGS-1:0] renVec;

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    logic [TAG_W-1:0] entryTag;
    assign entryTag    = tagFlat[g*TAG_W +: TAG_W];
    // a ready entry (tag 0) never matches, so a zero-tag broadcast is inert
    assign matchVec[g] = bcastEn && (entryTag != '0) && (entryTag == bcastTag);
    assign renVec[g]   = renEn && (renReg == ADDR_W'(g));
  end

  always_comb begin
    strb.renSel = renVec;
    strb.capSel = matchVec & ~renVec;   // rename has priority
    strb.fwdA   = matchVec[rdAddrA];
    strb.fwdB   = matchVec[rdAddrB];
  end
endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobes_t                strb,
  input  logic [TAG_W-1:0]        renTag,
  input  logic [DATA_W-1:0]       bcastVal,
  input  logic [ADDR_W-1:0]       rdAddrA,
  input  logic [ADDR_W-1:0]       rdAddrB,
  output logic [NREGS*TAG_W-1:0]  tagFlat,
  output logic [DATA_W-1:0]       rdValA,
  output logic [TAG_W-1:0]        rdTagA,
  output logic [DATA_W-1:0]       rdValB,
  output logic [TAG_W-1:0]        rdTagB
);
  logic [NREGS*DATA_W-1:0] valFlat;

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    logic [DATA_W-1:0] valQ;
    logic [TAG_W-1:0]  tagQ;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valQ <= '0;
        tagQ <= '0;
      end else if (strb.renSel[g]) begin
        tagQ <= renTag;
      end else if (strb.capSel[g]) begin
        valQ <= bcastVal;
        tagQ <= '0;
      end
    end
    assign valFlat[g*DATA_W +: DATA_W] = valQ;
    assign tagFlat[g*TAG_W +: TAG_W]   = tagQ;
  end

  always_comb begin
    rdValA = strb.fwdA ? bcastVal : valFlat[int'(rdAddrA)*DATA_W +: DATA_W];
    rdTagA = strb.fwdA ? '0       : tagFlat[int'(rdAddrA)*TAG_W +: TAG_W];
    rdValB = strb.fwdB ? bcastVal : valFlat[int'(rdAddrB)*DATA_W +: DATA_W];
    rdTagB = strb.fwdB ? '0       : tagFlat[int'(rdAddrB)*TAG_W +: TAG_W];
  end
endmodule

// File: rtl/rename_table.sv
module rename_table
  import rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdValA,
  output logic [TAG_W-1:0]  rdTagA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdValB,
  output logic [TAG_W-1:0]  rdTagB,
  input  logic              renEn,
  input  logic [ADDR_W-1:0] renReg,
  input  logic [TAG_W-1:0]  renTag,
  input  logic              bcastEn,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastVal
);
  strobes_t               strb;
  logic [NREGS*TAG_W-1:0] tagFlat;

  rt_ctrl u_ctrl (
    .renEn(renEn), .renReg(renReg), .bcastEn(bcastEn), .bcastTag(bcastTag),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .tagFlat(tagFlat), .strb(strb)
  );

  rt_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .renTag(renTag), .bcastVal(bcastVal),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .tagFlat(tagFlat),
    .rdValA(rdValA), .rdTagA(rdTagA), .rdValB(rdValB), .rdTagB(rdTagB)
  );
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk
  import rt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rdAddrA,
  input logic [DATA_W-1:0] rdValA,
  input logic [TAG_W-1:0]  rdTagA,
  input logic [ADDR_W-1:0] rdAddrB,
  input logic [DATA_W-1:0] rdValB,
  input logic [TAG_W-1:0]  rdTagB,
  input logic              renEn,
  input logic [ADDR_W-1:0] renReg,
  input logic [TAG_W-1:0]  renTag,
  input logic              bcastEn,
  input logic [TAG_W-1:0]  bcastTag
);
  // rename is visible on the next read of that register unless bypassed
  assert_rename_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (renEn && renTag != '0) |=>
      (rdAddrA != $past(renReg)) || (bcastEn && bcastTag == $past(renTag)) ||
      (rdTagA == $past(renTag)));

  // a tag being broadcast is never reported as pending
  assert_fwd_clears_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcastEn && bcastTag != '0) |-> (rdTagA != bcastTag) && (rdTagB != bcastTag));

  // quiet cycles leave the addressed entry untouched
  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(renEn) && !$past(bcastEn) && $stable(rdAddrA) && !bcastEn) |->
      ($stable(rdValA) && $stable(rdTagA)));

  // zero-tag broadcast changes nothing
  assert_zero_tag_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bcastEn) && $past(bcastTag) == '0 && !$past(renEn) && $stable(rdAddrB) && !bcastEn) |->
      ($stable(rdValB) && $stable(rdTagB)));
endmodule

bind rename_table rename_table_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rdAddrA(rdAddrA), .rdValA(rdValA), .rdTagA(rdTagA),
  .rdAddrB(rdAddrB), .rdValB(rdValB), .rdTagB(rdTagB),
  .renEn(renEn), .renReg(renReg), .renTag(renTag),
  .bcastEn(bcastEn), .bcastTag(bcastTag)
);

// File: tb/rename_table_tb.sv
module rename_table_tb;
  import rt_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [ADDR_W-1:0] rdAddrA, rdAddrB, renReg;
  logic [DATA_W-1:0] rdValA, rdValB, bcastVal;
  logic [TAG_W-1:0]  rdTagA, rdTagB, renTag, bcastTag;
  logic              renEn, bcastEn;

  rename_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .rdAddrA(rdAddrA), .rdValA(rdValA), .rdTagA(rdTagA),
    .rdAddrB(rdAddrB), .rdValB(rdValB), .rdTagB(rdTagB),
    .renEn(renEn), .renReg(renReg), .renTag(renTag),
    .bcastEn(bcastEn), .bcastTag(bcastTag), .bcastVal(bcastVal)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] mVal [NREGS];
  logic [TAG_W-1:0]  mTag [NREGS];

  task automatic chk(input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit fwdHit(input int r, input logic bc, input logic [TAG_W-1:0] bt);
    return bc && (mTag[r] != '0) && (mTag[r] == bt);
  endfunction

  task automatic step(input logic ren, input int rReg, input logic [TAG_W-1:0] rTag,
                      input logic bc, input logic [TAG_W-1:0] bTag, input logic [DATA_W-1:0] bVal,
                      input int a, input int b, input string req);
    logic [DATA_W-1:0] nV [NREGS];
    logic [TAG_W-1:0]  nT [NREGS];
    string la, lb;
    @(negedge clk);
    renEn = ren; renReg = ADDR_W'(rReg); renTag = rTag;
    bcastEn = bc; bcastTag = bTag; bcastVal = bVal;
    rdAddrA = ADDR_W'(a); rdAddrB = ADDR_W'(b);
    #1;
    la = (req != "") ? req : (fwdHit(a, bc, bTag) ? "R6" : "R2");
    lb = (req != "") ? req : (fwdHit(b, bc, bTag) ? "R6" : "R2");
    chk(la, "valA", rdValA, fwdHit(a, bc, bTag) ? bVal : mVal[a]);
    chk(la, "tagA", DATA_W'(rdTagA), fwdHit(a, bc, bTag) ? '0 : DATA_W'(mTag[a]));
    chk(lb, "valB", rdValB, fwdHit(b, bc, bTag) ? bVal : mVal[b]);
    chk(lb, "tagB", DATA_W'(rdTagB), fwdHit(b, bc, bTag) ? '0 : DATA_W'(mTag[b]));
    for (int r = 0; r < NREGS; r++) begin
      nV[r] = mVal[r]; nT[r] = mTag[r];
      if (ren && rReg == r) nT[r] = rTag;
      else if (fwdHit(r, bc, bTag)) begin nV[r] = bVal; nT[r] = '0; end
    end
    @(posedge clk);
    #1;
    for (int r = 0; r < NREGS; r++) begin mVal[r] = nV[r]; mTag[r] = nT[r]; end
  endtask

  task automatic idle(input int a, input int b, input string req);
    step(1'b0, 0, '0, 1'b0, '0, '0, a, b, req);
  endtask

  initial begin
    rst_n = 1'b0; renEn = 1'b0; renReg = '0; renTag = '0;
    bcastEn = 1'b0; bcastTag = '0; bcastVal = '0; rdAddrA = '0; rdAddrB = '0;
    for (int r = 0; r < NREGS; r++) begin mVal[r] = '0; mTag[r] = '0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state of every entry
    for (int r = 0; r < NREGS; r++) idle(r, NREGS - 1 - r, "R1");

    // R9 then R3: same-cycle read sees old contents, next cycle sees tag 5
    step(1'b1, 3, 4'd5, 1'b0, '0, '0, 3, 3, "R9");
    idle(3, 3, "R3");

    // R6 then R4: two entries waiting on tag 5 both capture
    step(1'b1, 7, 4'd5, 1'b0, '0, '0, 7, 3, "R9");
    step(1'b0, 0, '0, 1'b1, 4'd5, 32'hA5A5_0001, 3, 7, "R6");
    idle(3, 7, "R4");

    // R5: superseded tag ignores old broadcast
    step(1'b1, 4, 4'd6, 1'b0, '0, '0, 4, 4, "R9");
    step(1'b1, 4, 4'd9, 1'b0, '0, '0, 0, 0, "R2");
    step(1'b0, 0, '0, 1'b1, 4'd6, 32'h1234_5678, 4, 4, "R5");
    idle(4, 4, "R5");

    // R7: rename and matching broadcast on the same entry
    step(1'b1, 8, 4'd1, 1'b0, '0, '0, 8, 8, "R9");
    step(1'b1, 8, 4'd2, 1'b1, 4'd1, 32'h0000_0077, 8, 8, "R6");
    idle(8, 8, "R7");

    // R8: zero-tag broadcast is inert
    step(1'b0, 0, '0, 1'b1, 4'd0, 32'hFFFF_FFFF, 3, 0, "R8");
    idle(3, 0, "R8");

    // R10: quiet cycles hold everything
    for (int r = 0; r < NREGS; r++) idle(r, (r + 5) % NREGS, "R10");

    // constrained random phase
    void'($urandom(32'd2718));
    for (int i = 0; i < 3000; i++) begin
      logic ren, bc;
      logic [TAG_W-1:0] rt, bt;
      ren = ($urandom % 3) == 0;
      bc  = ($urandom % 2) == 0;
      rt  = TAG_W'(1 + ($urandom % ((1 << TAG_W) - 1)));
      bt  = (($urandom % 4) != 0) ? mTag[$urandom % NREGS] : TAG_W'($urandom);
      step(ren, int'($urandom % NREGS), rt, bc, bt, $urandom,
           int'($urandom % NREGS), int'($urandom % NREGS), "");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule